// File: doc/BRIEF.md
# PSRAM Refresh Scheduler and Arbiter

This block keeps a pseudo-static RAM refreshed while a separate cycle controller uses it for reads and writes. It owns the chip-enable, chip-select and refresh pins. A free-running interval timer adds one owed refresh about every 15.6 us. Each owed refresh becomes a short low pulse on the refresh pin while chip-enable stays high, and the memory steps its own row counter. Host cycles are granted through a level request/grant handshake. A refresh that falls due waits until the current host cycle has finished its chip-enable precharge. It then takes the pins ahead of any new host request. Refreshes held off by a long host cycle are counted and paid back one after another.

On a sleep request, the scheduler holds the refresh pin low long enough that the memory enters self-refresh, and only then acknowledges. When the request is withdrawn, the refresh pin goes high for the self-refresh recovery time. An auto-refresh then follows at once, well inside the 15 us restart deadline. A mode input selects what follows that first refresh. In distributed mode it is a single refresh followed by the normal interval. In burst mode it is one full pass of back-to-back refreshes over every row, during which the host waits. All durations are derived from a core-clock frequency parameter and nanosecond timing parameters.

Top module: `psram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, chip-enable (active low) and refresh (active low) are high, and chip-select, grant, sleep acknowledge and busy are low.
- R2: An auto-refresh drives the refresh pin low for exactly 4 clock cycles (80 ns at 50 MHz) with chip-enable high, and raises busy while it lasts.
- R3: With no host activity, successive auto-refresh pulses start exactly 780 cycles apart (15.6 us at 50 MHz).
- R4: A host request with nothing owed is granted on the next clock, with chip-enable low and chip-select high, until the request drops. Chip-enable then stays high for exactly 3 cycles before a waiting host request is granted again.
- R5: Chip-enable and refresh are never low together. A host request raised during a refresh is granted exactly 10 cycles after that refresh pulse began.
- R6: Refreshes that fall due during a long host cycle are issued after it ends, one for each interval elapsed, with pulse starts 10 cycles apart. The owed count stays below the configured limit outside a post-sleep burst.
- R7: On a sleep request the refresh pin goes low with chip-enable high and chip-select high. The acknowledge rises after exactly 400 cycles (8 us) of low refresh and holds while the request stays.
- R8: When the sleep request drops, the acknowledge falls on the next clock. The refresh pin stays high for exactly 30 cycles (600 ns), and the first auto-refresh follows within 750 cycles (15 us).
- R9: In distributed mode (mode input low), only the one post-sleep refresh is issued before the regular interval resumes.
- R10: In burst mode (mode input high), exactly 2048 auto-refreshes follow the sleep exit back to back, 10 cycles apart, and a pending host request is granted 10 cycles after the last one begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Cycle controller requests the memory (level) |
| host_grant | output | 1 | Memory granted to the cycle controller |
| sched_busy | output | 1 | Scheduler owns the pins for refresh or sleep |
| sleep_req | input | 1 | Request to hold the memory in self-refresh |
| sleep_ack | output | 1 | Memory is in self-refresh |
| burst_mode | input | 1 | 1: full burst after sleep exit, 0: distributed |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_cs | output | 1 | Memory chip-select, active high |
| mem_rfsh_n | output | 1 | Memory refresh pin, active low |

## Verification
A corrupted owed-refresh count shows up at the refresh pin within one refresh cycle after the pins next fall idle. It appears as missing pulses or extra back-to-back pulses. A wrong duration counter changes a pulse or gap width on the very next refresh, precharge, sleep entry or wake-up, so the bench measures every width in cycles. A stuck interval timer becomes visible only after one full 780-cycle interval, which is why two consecutive idle refreshes are timed. A wrong post-sleep mode flag appears within the first few hundred cycles after the wake-up as a wrong pulse count before the host grant.

// File: rtl/psram_refresh_sched.sv
`timescale 1ns/1ps
module psram_refresh_sched #(
  parameter int CLK_MHZ      = 50,
  parameter int ROWS         = 2048,
  parameter int INTERVAL_NS  = 15600,
  parameter int PULSE_NS     = 80,
  parameter int CYCLE_NS     = 190,
  parameter int PRECHARGE_NS = 60,
  parameter int SELF_MIN_NS  = 8000,
  parameter int RECOVER_NS   = 600,
  parameter int EXIT_NS      = 15000,
  parameter int OWE_LIMIT    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  output logic host_grant,
  output logic sched_busy,
  input  logic sleep_req,
  output logic sleep_ack,
  input  logic burst_mode,
  output logic mem_ce_n,
  output logic mem_cs,
  output logic mem_rfsh_n
);
  localparam int FAP_C  = (PULSE_NS * CLK_MHZ + 999) / 1000;
  localparam int FC_C   = (CYCLE_NS * CLK_MHZ + 999) / 1000;
  localparam int REST_C = (FC_C > FAP_C) ? FC_C - FAP_C : 1;
  localparam int TP_C   = (PRECHARGE_NS * CLK_MHZ + 999) / 1000;
  localparam int FAS_C  = (SELF_MIN_NS * CLK_MHZ + 999) / 1000;
  localparam int FRS_C  = (RECOVER_NS * CLK_MHZ + 999) / 1000;
  localparam int INT_C  = (INTERVAL_NS * CLK_MHZ + 999) / 1000;
  localparam int EXIT_C = (EXIT_NS * CLK_MHZ) / 1000;
  localparam int CW     = $clog2(FAS_C + INT_C + 1) + 1;
  localparam int OW     = $clog2(ROWS + OWE_LIMIT + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_HOST, S_HPRE, S_RPUL, S_RPRE, S_SENT, S_SLEEP, S_WAKE
  } st_t;

  st_t st, nxt, pick;
  logic [CW-1:0] cnt, lim, tick_cnt;
  logic [OW-1:0] owed;
  logic done, tick, hold, bursting, wake;

  assign pick = (owed != '0) ? S_RPUL :
                sleep_req    ? S_SENT :
                host_req     ? S_HOST : S_IDLE;

  always_comb begin
    case (st)
      S_RPUL:  lim = CW'(FAP_C - 1);
      S_RPRE:  lim = CW'(REST_C - 1);
      S_HPRE:  lim = CW'(TP_C - 1);
      S_SENT:  lim = CW'(FAS_C - 1);
      S_WAKE:  lim = CW'(FRS_C - 1);
      default: lim = '0;
    endcase
  end
  assign done = (cnt == lim);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  nxt = pick;
      S_HOST:  nxt = host_req ? S_HOST : S_HPRE;
      S_HPRE,
      S_RPRE,
      S_WAKE:  if (done) nxt = pick;
      S_RPUL:  if (done) nxt = S_RPRE;
      S_SENT:  if (done) nxt = S_SLEEP;
      S_SLEEP: if (!sleep_req) nxt = S_WAKE;
      default: nxt = S_IDLE;
    endcase
  end

  assign wake = (st == S_SLEEP) && !sleep_req;
  assign hold = (st == S_SENT) || (st == S_SLEEP) || (st == S_WAKE) || bursting;
  assign tick = !hold && (tick_cnt == CW'(INT_C - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      tick_cnt <= '0;
      owed     <= '0;
      bursting <= 1'b0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? '0 : cnt + 1'b1;
      if (hold || tick) tick_cnt <= '0;
      else              tick_cnt <= tick_cnt + 1'b1;
      if (wake) owed <= burst_mode ? OW'(ROWS) : OW'(1);
      else      owed <= owed + OW'(tick) - OW'((st == S_RPUL) && done);
      if (wake)  bursting <= burst_mode;
      else       bursting <= bursting && (owed != '0);
    end
  end

  assign host_grant = (st == S_HOST);
  assign mem_ce_n   = (st != S_HOST);
  assign mem_cs     = (st == S_HOST) || (st == S_SENT) || (st == S_SLEEP);
  assign mem_rfsh_n = !((st == S_RPUL) || (st == S_SENT) || (st == S_SLEEP));
  assign sleep_ack  = (st == S_SLEEP);
  assign sched_busy = (st == S_RPUL) || (st == S_RPRE) || (st == S_SENT) ||
                      (st == S_SLEEP) || (st == S_WAKE);
endmodule

// File: rtl/psram_refresh_sched_chk.sv
`timescale 1ns/1ps
module psram_refresh_sched_chk #(
  parameter int FAP_C     = 4,
  parameter int EXIT_C    = 750,
  parameter int OWE_LIMIT = 8,
  parameter int OW        = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_grant,
  input logic          sleep_req,
  input logic          sleep_ack,
  input logic          mem_ce_n,
  input logic          mem_rfsh_n,
  input logic [OW-1:0] owed,
  input logic          bursting
);
  logic [15:0] lowcnt, wcnt;
  logic had_ack, waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt  <= '0;
      had_ack <= 1'b0;
      waiting <= 1'b0;
      wcnt    <= '0;
    end else begin
      lowcnt  <= mem_rfsh_n ? '0 : lowcnt + 1'b1;
      had_ack <= mem_rfsh_n ? 1'b0 : (had_ack | sleep_ack);
      if (sleep_ack)        waiting <= 1'b1;
      else if (!mem_rfsh_n) waiting <= 1'b0;
      wcnt <= (waiting && !sleep_ack) ? wcnt + 1'b1 : '0;
    end
  end

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_ce_n && !mem_rfsh_n));
  a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_grant) |-> $past(host_req));
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_rfsh_n) && !had_ack) |-> (lowcnt == 16'(FAP_C)));
  a_r7_ack_in_self_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> (!mem_rfsh_n && mem_ce_n));
  a_r8_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack) |-> !$past(sleep_req));
  a_r8_exit_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !sleep_ack) |-> (wcnt < 16'(EXIT_C)));
  a_r6_owed_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !bursting |-> (owed < OW'(OWE_LIMIT)));
endmodule

bind psram_refresh_sched psram_refresh_sched_chk #(
  .FAP_C(FAP_C), .EXIT_C(EXIT_C), .OWE_LIMIT(OWE_LIMIT), .OW(OW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_grant(host_grant),
  .sleep_req(sleep_req), .sleep_ack(sleep_ack), .mem_ce_n(mem_ce_n),
  .mem_rfsh_n(mem_rfsh_n), .owed(owed), .bursting(bursting)
);

// File: tb/psram_refresh_sched_test.sv
`timescale 1ns/1ps
module psram_refresh_sched_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, sleep_req = 1'b0, burst_mode = 1'b0;
  logic host_grant, sched_busy, sleep_ack, mem_ce_n, mem_cs, mem_rfsh_n;
  int cyc = 0, tests = 0, fails = 0, overlap = 0;
  bit finished = 0;

  psram_refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_grant(host_grant),
    .sched_busy(sched_busy), .sleep_req(sleep_req), .sleep_ack(sleep_ack),
    .burst_mode(burst_mode), .mem_ce_n(mem_ce_n), .mem_cs(mem_cs),
    .mem_rfsh_n(mem_rfsh_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && !mem_ce_n && !mem_rfsh_n) overlap++;

  // {hold cycles, re-request straight after release}
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{1,1}, '{2,0}, '{5,1}, '{17,1}, '{3,0}, '{40,0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fall(output int t);
    bit p = mem_rfsh_n;
    forever begin
      @(negedge clk);
      if (p && !mem_rfsh_n) break;
      p = mem_rfsh_n;
    end
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t1, t2, n, g, last, bad;
    bit p;
    repeat (4) @(negedge clk);
    chk({mem_ce_n, mem_rfsh_n, mem_cs, host_grant, sleep_ack, sched_busy} == 6'b110000,
        "R1", {mem_ce_n, mem_rfsh_n, mem_cs, host_grant, sleep_ack, sched_busy}, 6'b110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_ce_n, mem_rfsh_n, mem_cs, host_grant, sleep_ack, sched_busy} == 6'b110000,
        "R1", {mem_ce_n, mem_rfsh_n, mem_cs, host_grant, sleep_ack, sched_busy}, 6'b110000);

    // R2 / R3: idle auto-refresh width and spacing
    wait_fall(t1);
    chk(sched_busy && mem_ce_n, "R2", {sched_busy, mem_ce_n}, 3);
    n = 1;
    forever begin @(negedge clk); if (mem_rfsh_n) break; n++; end
    chk(n == 4, "R2", n, 4);
    wait_fall(t2);
    chk(t2 - t1 == 780, "R3", t2 - t1, 780);
    while (sched_busy) @(negedge clk);

    // R4: table of host accesses
    for (int i = 0; i < NV; i++) begin
      host_req = 1'b1;
      while (mem_ce_n) @(negedge clk);
      chk(host_grant && mem_cs, "R4", {host_grant, mem_cs}, 3);
      n = 0;
      while (!mem_ce_n) begin
        n++;
        if (n == VEC[i][0]) host_req = 1'b0;
        @(negedge clk);
      end
      chk(n == VEC[i][0], "R4", n, VEC[i][0]);
      if (VEC[i][1] != 0) begin
        host_req = 1'b1;
        g = 0;
        while (mem_ce_n) begin g++; @(negedge clk); end
        chk(g == 3, "R4", g, 3);
        n = 0;
        while (!mem_ce_n) begin
          n++;
          if (n == 1) host_req = 1'b0;
          @(negedge clk);
        end
      end
      repeat (5) @(negedge clk);
    end

    // R5: host request during refresh waits exactly one refresh cycle
    wait_fall(t1);
    host_req = 1'b1;
    g = 0;
    while (mem_ce_n) begin @(negedge clk); g++; end
    chk(g == 10, "R5", g, 10);

    // R6: long host cycle, owed refreshes paid back to back
    while (cyc < t1 + 2450) @(negedge clk);
    host_req = 1'b0;
    wait_fall(last);
    n = 1; bad = 0; p = mem_rfsh_n;
    forever begin
      @(negedge clk);
      if (p && !mem_rfsh_n) begin
        if (cyc - last != 10) bad++;
        n++; last = cyc;
      end
      p = mem_rfsh_n;
      if (cyc - last > 60) break;
    end
    chk(n == 3, "R6", n, 3);
    chk(bad == 0, "R6", bad, 0);

    // R7: sleep entry
    sleep_req = 1'b1;
    @(negedge clk);
    chk({mem_rfsh_n, mem_ce_n, mem_cs, sched_busy} == 4'b0111, "R7",
        {mem_rfsh_n, mem_ce_n, mem_cs, sched_busy}, 4'b0111);
    n = 1;
    forever begin
      @(negedge clk);
      if (sleep_ack || mem_rfsh_n) break;
      n++;
    end
    chk(n == 400 && sleep_ack, "R7", n, 400);
    bad = 0;
    repeat (1500) begin
      @(negedge clk);
      if (mem_rfsh_n || !sleep_ack || !mem_cs) bad++;
    end
    chk(bad == 0, "R7", bad, 0);

    // R8: wake-up
    sleep_req = 1'b0;
    @(negedge clk);
    chk(!sleep_ack && mem_rfsh_n, "R8", {sleep_ack, mem_rfsh_n}, 1);
    g = 1;
    forever begin @(negedge clk); if (!mem_rfsh_n) break; g++; end
    chk(g == 30, "R8", g, 30);
    chk(g < 750, "R8", g, 750);

    // R9: distributed mode, no further refresh right away
    while (!mem_rfsh_n) @(negedge clk);
    n = 0; p = mem_rfsh_n;
    repeat (700) begin
      @(negedge clk);
      if (p && !mem_rfsh_n) n++;
      p = mem_rfsh_n;
    end
    chk(n == 0, "R9", n, 0);

    // R10: burst mode after sleep, host held off
    burst_mode = 1'b1;
    sleep_req = 1'b1;
    while (!sleep_ack) @(negedge clk);
    repeat (3) @(negedge clk);
    sleep_req = 1'b0;
    host_req = 1'b1;
    n = 0; bad = 0; last = 0; p = mem_rfsh_n;
    forever begin
      @(negedge clk);
      if (p && !mem_rfsh_n) begin
        if (n > 0 && cyc - last != 10) bad++;
        n++; last = cyc;
      end
      p = mem_rfsh_n;
      if (!mem_ce_n) break;
    end
    chk(n == 2048, "R10", n, 2048);
    chk(bad == 0, "R10", bad, 0);
    chk(cyc - last == 10, "R10", cyc - last, 10);
    host_req = 1'b0;
    burst_mode = 1'b0;
    repeat (10) @(negedge clk);

    chk(overlap == 0, "R5", overlap, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule